// File: doc/BRIEF.md
# Wishbone Register Bank Slave

This block is a small memory-mapped peripheral that sits on a classic Wishbone bus as a slave. It holds a parameterised number of 32-bit read/write registers that a processor core reaches through ordinary single reads and writes. Any byte lane of a register can be written on its own.

The acknowledge comes from a flip-flop and is never derived combinationally from the strobe and cycle inputs. A request seen on one clock edge is answered with an acknowledge on that edge, so the acknowledge is visible during the following cycle. A write is committed on the same edge that raises the acknowledge. Read data appears on the data output while the acknowledge is high. The master must hold address, data and control steady until it sees the acknowledge. Error, retry, bursts and the pipelined mode are not supported.

Top module: `wb_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and holds the acknowledge low.
- R2: A request is `cyc_i` and `stb_i` both high at a rising clock edge. It raises `ack_o` on that edge, so `ack_o` is high for the cycle after the request. `ack_o` is never high in the cycle where the request first appears.
- R3: `ack_o` is a single-cycle pulse that always drops on the next edge. If the strobe is held high across accesses, each acknowledge ends one request, and a new request is taken on the following edge. The result is one acknowledge every second cycle.
- R4: A write (`we_i` high) updates byte lane k (bits 8k+7:8k) only when `sel_i[k]` is 1, and leaves the other lanes unchanged. The write takes effect on the edge that raises `ack_o`.
- R5: During the acknowledge cycle of a read, `dat_o` carries the register at word address `adr_i`. Register i sits at address i for i below NREGS (4 by default).
- R6: Addresses at or above NREGS read as zero, and writes to them change no register.
- R7: `dat_o` is zero whenever `ack_o` is low, and it is also zero during the acknowledge of a write.
- R8: If `cyc_i` falls before a request is sampled, the access is dropped. No acknowledge follows and no write takes effect. A strobe with `cyc_i` low is likewise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| sel_i | input | 4 | Byte-lane enables for writes |
| adr_i | input | 4 | Word address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Registered acknowledge pulse |

## Verification
A corrupted register lane stays hidden until that register is read back. After a write, the bench therefore follows each write with reads at random addresses, and it re-reads every register after the directed corner cases, so a bad lane shows up on `dat_o` within a few accesses. A wrong acknowledge state shows up at once. A stuck acknowledge fails the check in the cycle after the pulse, and a missing one fails the check in the cycle after the request. A write that was abandoned or unmapped but committed anyway appears on the next read of the register it should not have changed.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int LANE_W = 8;

  // Expand per-lane enables into a bit mask.
  function automatic logic [LANE_W-1:0] lane_fill(input logic en);
    return {LANE_W{en}};
  endfunction

  // Merge new lane contents over old ones where enabled.
  function automatic logic [LANE_W-1:0] lane_merge(input logic [LANE_W-1:0] old_v,
                                                   input logic [LANE_W-1:0] new_v,
                                                   input logic en);
    logic [LANE_W-1:0] m;
    m = lane_fill(en);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/wbr_ack_gen.sv
module wbr_ack_gen (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cyc_i,
  input  logic stb_i,
  output logic req_start,
  output logic ack
);
  logic ack_q;

  // A request is accepted only when no acknowledge is currently showing.
  assign req_start = cyc_i & stb_i & ~ack_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= req_start;
  end

  assign ack = ack_q;
endmodule

// File: rtl/wbr_reg_file.sv
module wbr_reg_file #(
  parameter int DW    = 32,
  parameter int NREGS = 4,
  parameter int IW    = 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW/8-1:0]     wr_sel,
  input  logic [DW-1:0]       wr_data,
  output logic [NREGS*DW-1:0] reg_flat
);
  import wbr_pkg::*;
  localparam int LANES = DW / LANE_W;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(r));
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)    lane_q <= '0;
        else if (hit) lane_q <= lane_merge(lane_q, wr_data[l*LANE_W +: LANE_W], wr_sel[l]);
      end
      assign reg_flat[r*DW + l*LANE_W +: LANE_W] = lane_q;
    end
  end
endmodule

// File: rtl/wbr_read_mux.sv
module wbr_read_mux #(
  parameter int DW    = 32,
  parameter int NREGS = 4,
  parameter int IW    = 2
) (
  input  logic [NREGS*DW-1:0] reg_flat,
  input  logic                rd_en,
  input  logic [IW-1:0]       rd_idx,
  output logic [DW-1:0]       rd_data
);
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (rd_en && rd_idx == IW'(r)) rd_data = reg_flat[r*DW +: DW];
    end
  end
endmodule

// File: rtl/wb_regbank.sv
module wb_regbank #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NREGS = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [DW/8-1:0] sel_i,
  input  logic [AW-1:0]   adr_i,
  input  logic [DW-1:0]   dat_i,
  output logic [DW-1:0]   dat_o,
  output logic            ack_o
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [AW:0] LIMIT = (AW+1)'(NREGS);

  logic                req_start;
  logic                wr_commit;
  logic                rd_en;
  logic                mapped;
  logic [IW-1:0]       idx;
  logic [NREGS*DW-1:0] reg_flat;

  assign mapped    = {1'b0, adr_i} < LIMIT;
  assign idx       = adr_i[IW-1:0];
  assign wr_commit = req_start & we_i & mapped;
  assign rd_en     = ack_o & ~we_i & mapped;

  wbr_ack_gen u_ack (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cyc_i    (cyc_i),
    .stb_i    (stb_i),
    .req_start(req_start),
    .ack      (ack_o)
  );

  wbr_reg_file #(.DW(DW), .NREGS(NREGS), .IW(IW)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_en   (wr_commit),
    .wr_idx  (idx),
    .wr_sel  (sel_i),
    .wr_data (dat_i),
    .reg_flat(reg_flat)
  );

  wbr_read_mux #(.DW(DW), .NREGS(NREGS), .IW(IW)) u_rmux (
    .reg_flat(reg_flat),
    .rd_en   (rd_en),
    .rd_idx  (idx),
    .rd_data (dat_o)
  );
endmodule

// File: rtl/wbr_checker.sv
module wbr_checker #(
  parameter int DW    = 32,
  parameter int NREGS = 4
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                cyc_i,
  input logic                stb_i,
  input logic                req_start,
  input logic                wr_commit,
  input logic                ack_o,
  input logic [DW-1:0]       dat_o,
  input logic [NREGS*DW-1:0] reg_flat
);
  assert_ack_follows_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    req_start |=> ack_o);

  assert_ack_has_cause_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> $past(cyc_i && stb_i));

  assert_ack_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);

  assert_commit_acked_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_commit |=> ack_o);

  assert_idle_data_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !ack_o |-> dat_o == '0);

  assert_no_stray_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_commit |=> $stable(reg_flat));
endmodule

bind wb_regbank wbr_checker #(.DW(DW), .NREGS(NREGS)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .cyc_i    (cyc_i),
  .stb_i    (stb_i),
  .req_start(req_start),
  .wr_commit(wr_commit),
  .ack_o    (ack_o),
  .dat_o    (dat_o),
  .reg_flat (reg_flat)
);

// File: tb/sim_wb_regbank.sv
`timescale 1ns/1ps
module sim_wb_regbank;
  logic        clk = 1'b0;
  logic        rst, cyc, stb, we;
  logic [3:0]  sel, adr;
  logic [31:0] dati, dato;
  logic        ack;
  int          tests = 0;
  int          fails = 0;
  logic [31:0] model [4];

  always #2 clk = ~clk;

  wb_regbank u0 (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .sel_i(sel), .adr_i(adr), .dat_i(dati), .dat_o(dato), .ack_o(ack)
  );

  function automatic logic [31:0] merge_bytes(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] s);
    logic [31:0] mask;
    mask = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (o & ~mask) | (n & mask);
  endfunction

  function automatic logic [31:0] expect_read(input logic w, input logic [3:0] a);
    if (w || a >= 4) return 32'h0;
    return model[a[1:0]];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic [3:0] s,
                        input logic [31:0] d);
    logic [31:0] e;
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; sel = s; dati = d;
    #1 check(ack == 1'b0, "R2 no same-cycle ack", 32'(ack), 0);
    @(negedge clk);
    check(ack == 1'b1, "R2 ack next cycle", 32'(ack), 1);
    e = expect_read(w, a);
    check(dato == e, w ? "R7 write data zero" : (a < 4 ? "R5 read" : "R6 unmapped read"),
          dato, e);
    if (w && a < 4) model[a[1:0]] = merge_bytes(model[a[1:0]], d, s);
    cyc = 0; stb = 0;
    @(negedge clk);
    check(ack == 1'b0, "R3 ack drops", 32'(ack), 0);
    check(dato == 32'h0, "R7 idle data zero", dato, 0);
  endtask

  task automatic read_all();
    for (int i = 0; i < 4; i++) access(1'b0, 4'(i), 4'hF, 32'h0);
  endtask

  initial begin
    #800000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed));
    rst = 1; cyc = 0; stb = 0; we = 0; sel = 0; adr = 0; dati = 0;
    for (int i = 0; i < 4; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    check(ack == 1'b0, "R1 ack low in reset", 32'(ack), 0);
    rst = 0;
    read_all();                                  // R1 registers cleared
    access(1'b0, 4'd7, 4'hF, 32'h0);             // R6 unmapped reads zero

    access(1'b1, 4'd1, 4'hF, 32'h11223344);      // R4 full write
    access(1'b0, 4'd1, 4'hF, 32'h0);
    access(1'b1, 4'd1, 4'b0101, 32'hFFFFFFFF);   // R4 partial lanes
    access(1'b0, 4'd1, 4'hF, 32'h0);
    access(1'b1, 4'd3, 4'b1000, 32'hA5000000);
    access(1'b1, 4'd9, 4'hF, 32'hDEADBEEF);      // R6 unmapped write ignored
    read_all();
    access(1'b0, 4'd9, 4'hF, 32'h0);

    // R3 held strobe: acknowledges on alternate cycles
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = 4'd1; sel = 4'hF;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (ack) cnt++;
    end
    check(cnt == 2, "R3 one ack per two cycles", 32'(cnt), 2);
    cyc = 0; stb = 0;
    @(negedge clk);

    // R8 cycle dropped before request is sampled
    cyc = 1; stb = 1; we = 1; adr = 4'd2; sel = 4'hF; dati = 32'hCAFEF00D;
    #0.5 cyc = 0;
    @(negedge clk);
    check(ack == 1'b0, "R8 abandoned no ack", 32'(ack), 0);
    // R8 strobe without cycle
    @(negedge clk);
    check(ack == 1'b0, "R8 stb without cyc no ack", 32'(ack), 0);
    stb = 0; we = 0;
    access(1'b0, 4'd2, 4'hF, 32'h0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      access(1'($urandom_range(1)), 4'($urandom_range(7)), 4'($urandom_range(15)), $urandom());
    end
    read_all();

    // R1 reset mid-run clears everything
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 4; i++) model[i] = 32'h0;
    read_all();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule